// File: doc/BRIEF.md
# Under-Voltage Fault Shutdown Manager

This block decides, for four regulator channels, when each channel's drive must be forced off. Each channel supplies a digital under-voltage flag from an external comparator, an "on" indication from the power sequencer, and a "soft-start done" indication. Two configuration bytes arrive from a register file. The protection byte holds a per-channel fault-enable bit and a global "shut everything on any fault" bit. The software-shutdown byte holds one forcing bit per channel. The block returns one shutdown request per channel to the sequencer. It also returns a one-cycle restart request when the channel 1 software shutdown is released while the supply is good.

Each channel runs its own state machine with four states. `CH_OFF` means the channel is not on. `CH_RAMP` means the channel is on and soft-start has not finished. `CH_WATCH` means the channel is on, settled and monitored. `CH_TRIP` means a fault is latched. The transitions are as follows:
- Power-up (`CH_OFF`→`CH_RAMP` when on rises).
- Settle (`CH_RAMP`→`CH_WATCH` on soft-start done).
- Local trip (`CH_WATCH`→`CH_TRIP` on an enabled flagged fault).
- Global trip (`CH_RAMP`/`CH_WATCH`→`CH_TRIP` when all-channel mode is set and any channel trips).
- Drop (any state→`CH_OFF` when on is low).

A latched trip is held until the sequencer turns the channel off.

Top module: `uv_shutdown_mgr`

## Requirements
- R1: After an asynchronous active-low reset, every channel is in `CH_OFF`, `shut_req` is 4'b0000 and `restart_req` is 0 (with the software-shutdown byte at zero).
- R2: The under-voltage flag of a channel is ignored while the channel is off or in `CH_RAMP` (soft-start not done): no shutdown results.
- R3: A channel in `CH_WATCH` whose flag is high at a clock edge, with its fault-enable bit set, drives its `shut_req` bit high from that edge on. Vector bit i of `ch_on`, `ss_done`, `uv_flag` and `shut_req` is channel i+1.
- R4: The fault-enable bits in `prot_cfg` are bit 3 for channel 1, bit 2 for channel 2, bit 1 for channel 3 and bit 0 for channel 4. When a channel's bit is 0, its flag never shuts it down.
- R5: A latched trip stays latched while the channel remains on, even after the flag clears.
- R6: Dropping `ch_on` for a channel returns it to `CH_OFF` at the next edge and clears its trip. Re-enabling starts a new `CH_RAMP`.
- R7: With `prot_cfg` bit 4 set, an enabled trip on any channel latches a trip on every channel that is on (ramping or monitored) at the same edge. Channels that are off are untouched.
- R8: `swoff_cfg` bits 7, 6, 5 and 4 force `shut_req` of channels 1, 2, 3 and 4 high at once, combinationally, whatever the channel's state.
- R9: When `swoff_cfg` bit 7 goes from 1 to 0 and `supply_ok` is high at the edge that samples the 0, `restart_req` is high for exactly one cycle after that edge.
- R10: Releasing bit 6, 5 or 4 of `swoff_cfg` produces no restart request, and releasing bit 7 while `supply_ok` is low produces none either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_on | input | 4 | Channel is on, from the sequencer |
| ss_done | input | 4 | Soft-start of the channel has finished |
| uv_flag | input | 4 | Under-voltage comparator flag per channel |
| prot_cfg | input | 8 | Protection byte: fault-enables in bits 3..0, all-channel mode in bit 4 |
| swoff_cfg | input | 8 | Software-shutdown byte: channels 1..4 in bits 7..4 |
| supply_ok | input | 1 | Supply-good indication |
| shut_req | output | 4 | Shutdown request per channel |
| restart_req | output | 1 | One-cycle request to soft-start channel 1 again |

## Verification
The assertions check several behaviours on every cycle:
- A trip, once latched, is held while the channel stays on.
- Dropping `ch_on` always lands the channel in `CH_OFF`.
- An enabled fault in `CH_WATCH` or a global trip always reaches `CH_TRIP`.
- A ramping channel never trips from its own flag.
- The restart request is a single-cycle pulse that never appears without supply-good.

The decoding of configuration bit positions cannot be shown by those properties. Neither can the difference between releasing channel 1 and releasing channels 2–4, nor the exclusion of off channels from an all-channel shutdown. Only the bench scenarios, compared cycle by cycle against the reference model, can demonstrate those.

// File: rtl/uvg_pkg.sv
package uvg_pkg;
    typedef enum logic [1:0] {
        CH_OFF   = 2'd0,
        CH_RAMP  = 2'd1,
        CH_WATCH = 2'd2,
        CH_TRIP  = 2'd3
    } ch_state_e;
endpackage

// File: rtl/uvg_chan.sv
module uvg_chan
    import uvg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ch_on,
    input  logic ss_done,
    input  logic uv,
    input  logic fault_en,
    input  logic glob_trip,
    output logic local_trip,
    output logic tripped
);
    ch_state_e st_q, st_d;

    // next-state logic
    always_comb begin
        st_d = st_q;
        if (!ch_on) begin
            st_d = CH_OFF;
        end else begin
            unique case (st_q)
                CH_OFF:   st_d = CH_RAMP;
                CH_RAMP:  st_d = glob_trip ? CH_TRIP : (ss_done ? CH_WATCH : CH_RAMP);
                CH_WATCH: st_d = (glob_trip || (uv && fault_en)) ? CH_TRIP : CH_WATCH;
                CH_TRIP:  st_d = CH_TRIP;
                default:  st_d = CH_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CH_OFF;
        else        st_q <= st_d;
    end

    // outputs
    always_comb begin
        local_trip = 1'b0;
        tripped    = 1'b0;
        unique case (st_q)
            CH_WATCH: local_trip = ch_on && uv && fault_en;
            CH_TRIP:  tripped    = 1'b1;
            default:  ;
        endcase
    end

    // R5
    trip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_TRIP && ch_on) |=> st_q == CH_TRIP);

    // R6
    drop_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_on |=> st_q == CH_OFF);

    // R3
    watch_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_WATCH && ch_on && uv && fault_en) |=> st_q == CH_TRIP);

    // R2
    ramp_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != CH_WATCH && st_q != CH_TRIP && !glob_trip) |=> st_q != CH_TRIP);

    // R7
    glob_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (glob_trip && ch_on && st_q != CH_OFF) |=> st_q == CH_TRIP);
endmodule

// File: rtl/uvg_restart.sv
module uvg_restart (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_bit,
    input  logic supply_ok,
    output logic pulse
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            pulse  <= 1'b0;
        end else begin
            prev_q <= sw_bit;
            pulse  <= prev_q && !sw_bit && supply_ok;
        end
    end

    // R9
    one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);

    // R10
    no_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> !pulse);
endmodule

// File: rtl/uv_shutdown_mgr.sv
module uv_shutdown_mgr #(
    parameter int N_CH  = 4,
    parameter int CFG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_CH-1:0]  ch_on,
    input  logic [N_CH-1:0]  ss_done,
    input  logic [N_CH-1:0]  uv_flag,
    input  logic [CFG_W-1:0] prot_cfg,
    input  logic [CFG_W-1:0] swoff_cfg,
    input  logic             supply_ok,
    output logic [N_CH-1:0]  shut_req,
    output logic             restart_req
);
    localparam int EN_TOP   = N_CH - 1;
    localparam int MODE_BIT = N_CH;
    localparam int SW_TOP   = CFG_W - 1;

    logic [N_CH-1:0] fault_en;
    logic [N_CH-1:0] sw_off;
    logic [N_CH-1:0] local_trip;
    logic [N_CH-1:0] tripped;
    logic            glob_trip;

    assign glob_trip = prot_cfg[MODE_BIT] && (|local_trip);

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        assign fault_en[i] = prot_cfg[EN_TOP - i];
        assign sw_off[i]   = swoff_cfg[SW_TOP - i];

        uvg_chan u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .ch_on      (ch_on[i]),
            .ss_done    (ss_done[i]),
            .uv         (uv_flag[i]),
            .fault_en   (fault_en[i]),
            .glob_trip  (glob_trip),
            .local_trip (local_trip[i]),
            .tripped    (tripped[i])
        );

        assign shut_req[i] = tripped[i] || sw_off[i];
    end

    uvg_restart u_restart (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_bit    (sw_off[0]),
        .supply_ok (supply_ok),
        .pulse     (restart_req)
    );

    // R8
    swoff_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swoff_cfg[SW_TOP] |-> shut_req[0]);
endmodule

// File: tb/tb_uv_shutdown_mgr.sv
module tb_uv_shutdown_mgr;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] ch_on = '0, ss_done = '0, uv_flag = '0;
    logic [7:0] prot_cfg = 8'h0F, swoff_cfg = 8'h00;
    logic       supply_ok = 1'b1;
    logic [3:0] shut_req;
    logic       restart_req;

    int total = 0, bad = 0, cyc = 0;
    string tag = "R1";
    int m_st [4];
    bit m_prev, m_rst;

    uv_shutdown_mgr dut (.*);

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            bad++; total++;
            $display("FAIL watchdog: act=hung exp=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic bit fen(int i); return prot_cfg[3-i]; endfunction

    task automatic chk4(string t, logic [3:0] act, logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: act=%b exp=%b", t, act, exp);
        end
    endtask

    task automatic chk1(string t, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: act=%b exp=%b", t, act, exp);
        end
    endtask

    // one clock: update the reference at the edge, compare at the falling edge
    task automatic step();
        bit any;
        bit loc [4];
        @(posedge clk);
        any = 0;
        for (int i = 0; i < 4; i++) begin
            loc[i] = (m_st[i] == 2) && ch_on[i] && uv_flag[i] && fen(i);
            any |= loc[i];
        end
        any = any && prot_cfg[4];
        for (int i = 0; i < 4; i++) begin
            if (!ch_on[i])       m_st[i] = 0;
            else if (m_st[i]==0) m_st[i] = 1;
            else if (m_st[i]==1) m_st[i] = any ? 3 : (ss_done[i] ? 2 : 1);
            else if (m_st[i]==2) m_st[i] = (loc[i] || any) ? 3 : 2;
        end
        m_rst  = m_prev && !swoff_cfg[7] && supply_ok;
        m_prev = swoff_cfg[7];
        @(negedge clk);
        begin
            logic [3:0] e;
            for (int i = 0; i < 4; i++) e[i] = (m_st[i] == 3) || swoff_cfg[7-i];
            chk4(tag, shut_req, e);
        end
        chk1(tag, restart_req, m_rst);
    endtask

    task automatic steps(int n);
        for (int k = 0; k < n; k++) step();
    endtask

    initial begin
        for (int i = 0; i < 4; i++) m_st[i] = 0;
        m_prev = 0; m_rst = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        tag = "R1";
        chk4("R1 reset shut", shut_req, 4'b0000);
        chk1("R1 reset restart", restart_req, 1'b0);
        steps(2);

        // R2: flags ignored while off and while ramping
        tag = "R2";
        uv_flag = 4'b0001;
        steps(2);
        ch_on = 4'b0001;
        steps(4);
        chk4("R2 ramp ignores flag", shut_req, 4'b0000);

        // R3: settle then trip channel 1
        uv_flag = 4'b0000; ss_done = 4'b0001;
        steps(2);
        tag = "R3";
        uv_flag = 4'b0001;
        step();
        chk4("R3 trip ch1", shut_req, 4'b0001);

        // R5: latched after flag clears
        tag = "R5";
        uv_flag = 4'b0000;
        steps(3);
        chk4("R5 latch held", shut_req, 4'b0001);

        // R6: drop clears, re-enable ramps
        tag = "R6";
        ch_on = 4'b0000;
        step();
        chk4("R6 drop clears", shut_req, 4'b0000);
        ch_on = 4'b0001; ss_done = 4'b0000;
        steps(2);
        chk4("R6 re-enable no trip", shut_req, 4'b0000);

        // R4: channel 2 fault-enable (bit 2) cleared
        tag = "R4";
        prot_cfg = 8'h0B;
        ch_on = 4'b0011; ss_done = 4'b0011;
        steps(3);
        uv_flag = 4'b0010;
        steps(3);
        chk4("R4 disabled fault ignored", shut_req, 4'b0000);
        uv_flag = 4'b0000; prot_cfg = 8'h0F;
        ch_on = 4'b0000; ss_done = 4'b0000;
        steps(2);

        // R7: all-channel mode, channel 4 off, channel 2 ramping
        tag = "R7";
        prot_cfg = 8'h1F;
        ch_on = 4'b0111; ss_done = 4'b0101;
        steps(3);
        uv_flag = 4'b0100;
        step();
        chk4("R7 shut all on", shut_req, 4'b0111);
        uv_flag = 4'b0000;
        ch_on = 4'b0000; ss_done = 4'b0000; prot_cfg = 8'h0F;
        steps(2);

        // R8: software shutdown is combinational
        tag = "R8";
        swoff_cfg = 8'h20;
        #1;
        chk4("R8 swoff ch3 immediate", shut_req, 4'b0100);
        steps(2);
        swoff_cfg = 8'hF0;
        #1;
        chk4("R8 swoff all", shut_req, 4'b1111);
        steps(2);

        // R10: releasing channels 2..4 gives no restart
        tag = "R10";
        swoff_cfg = 8'h80;
        step();
        chk1("R10 ch2-4 release no restart", restart_req, 1'b0);
        step();

        // R9: release channel 1 with supply good
        tag = "R9";
        swoff_cfg = 8'h00;
        step();
        chk1("R9 restart pulse", restart_req, 1'b1);
        step();
        chk1("R9 pulse one cycle", restart_req, 1'b0);

        // R10: release channel 1 with supply low
        tag = "R10";
        swoff_cfg = 8'h80;
        steps(2);
        supply_ok = 1'b0;
        swoff_cfg = 8'h00;
        step();
        chk1("R10 no restart without supply", restart_req, 1'b0);
        steps(2);
        supply_ok = 1'b1;
        steps(2);

        // R1: asynchronous reset clears a latched trip
        tag = "R1";
        ch_on = 4'b1000; ss_done = 4'b1000;
        steps(3);
        uv_flag = 4'b1000;
        step();
        chk4("R3 trip ch4", shut_req, 4'b1000);
        uv_flag = 4'b0000;
        #2 rst_n = 1'b0;
        #1;
        chk4("R1 async reset clears", shut_req, 4'b0000);
        for (int i = 0; i < 4; i++) m_st[i] = 0;
        m_prev = 0; m_rst = 0;
        ch_on = 4'b0000; ss_done = 4'b0000;
        @(negedge clk);
        rst_n = 1'b1;
        steps(2);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule